// File: doc/BRIEF.md
# Arithmetic Status Flag Unit

This block performs one 8-bit or 16-bit arithmetic or logic operation on two operands and keeps the status flags that describe the outcome. The supported operations are add, add with carry, subtract, subtract with borrow, AND, OR and XOR. The result is available combinationally in the same cycle that the operands are applied. The six status flags (carry, parity, auxiliary carry, zero, sign and overflow) are captured on the clock edge when the flag-write enable is high.

Three control bits sit in the same flag register: direction, interrupt enable and trap. Arithmetic never changes them. Software-style set and clear masks change them directly. A surrounding execution core uses the result at once, and it reads the registered flags from the following cycle on. In particular, the carry-chained operations read the stored carry as their incoming carry or borrow.

Top module: `status_flag_unit`

## Requirements
- R1: Operation code 0 (add) gives result = A + B at the operation width. Code 1 (add with carry) also adds the stored carry flag. Carry is set exactly when the true sum does not fit the width.
- R2: Code 2 (subtract) gives result = A - B. Code 3 (subtract with borrow) also subtracts the stored carry flag. Carry is set exactly when a borrow is needed, that is, when the unsigned minuend is smaller than the subtrahend plus the incoming borrow.
- R3: Overflow is set after an arithmetic operation exactly when the two's-complement result lies outside the signed range of the operation width.
- R4: Auxiliary carry is set after an arithmetic operation exactly when there is a carry out of, or a borrow into, the low nibble (bit 3 to bit 4), counting the incoming carry or borrow.
- R5: Parity is set when bits 7..0 of the result hold an even number of ones. This holds in word mode as well.
- R6: Zero is set when the result is all zeros at the operation width. Sign copies the result's top bit at that width (bit 7 when word_sel=0, bit 15 when word_sel=1). In byte mode, result[15:8] reads 0.
- R7: Codes 4, 5 and 6 (AND, OR, XOR) give the bitwise result. They clear carry, overflow and auxiliary carry.
- R8: Status flags change only on a clock edge where flag_we=1 and the code is 0 to 6. Code 7 leaves every flag unchanged and drives the result with op_a at the operation width.
- R9: Control bits are updated every clock as new = (old AND NOT ctl_clr) OR ctl_set, so set wins over clear. Arithmetic operations never alter them.
- R10: Flag vector layout: bit0 carry, bit1 parity, bit2 auxiliary carry, bit3 zero, bit4 sign, bit5 overflow, bit6 direction, bit7 interrupt enable, bit8 trap. All nine bits are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 16 | First operand (minuend for subtract) |
| op_b | input | 16 | Second operand |
| op_code | input | 3 | Operation select, codes 0 to 7 |
| word_sel | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| flag_we | input | 1 | Capture the status flags at the next edge |
| ctl_set | input | 3 | Set mask for {trap, interrupt enable, direction} |
| ctl_clr | input | 3 | Clear mask for {trap, interrupt enable, direction} |
| result | output | 16 | Combinational operation result |
| flags | output | 9 | Registered flag vector |

## Verification
A corrupted stored carry shows up in the very next add-with-carry or subtract-with-borrow result, in the same cycle that operation is applied. Afterwards it propagates through every flag that the operation captures. A wrong flag capture or hold appears on the flag vector one clock after the offending edge. The reference model is compared against the result before every edge and against all nine flags after every edge, so a divergence is reported within one cycle of its cause. Mixed byte and word operations with random operands drive the borrow, nibble-carry and overflow boundaries. Directed cases then hit the exact edges of each of those boundaries.

// File: rtl/sfu_pkg.sv
// Shared definitions for the status flag unit.
// Assumes the flag vector layout documented in the brief (carry at bit 0).
package sfu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_XOR = 3'd6,
        OP_NOP = 3'd7
    } sfu_op_e;

    // Status flags, carry in the least significant position
    typedef struct packed {
        logic ovf;
        logic sign;
        logic zero;
        logic aux;
        logic parity;
        logic carry;
    } stat_flags_t;

    // Control bits, direction in the least significant position
    typedef struct packed {
        logic trap;
        logic ie;
        logic dir;
    } ctl_flags_t;

    localparam int NIBBLE_BIT = 4;
    localparam int STAT_W     = $bits(stat_flags_t);
    localparam int CTL_W      = $bits(ctl_flags_t);

endpackage

// File: rtl/sfu_parity.sv
// Even-parity detector over a LANES-bit slice.
// Assumes LANES >= 1. Output is 1 when the count of ones is even.
module sfu_parity #(
    parameter int LANES = 8
) (
    input  logic [LANES-1:0] bits_in,
    output logic             even_out
);

    logic [LANES:0] chain;

    assign chain[0] = 1'b0;

    // Ripple XOR chain, one stage per lane
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign chain[i+1] = chain[i] ^ bits_in[i];
        end
    endgenerate

    assign even_out = ~chain[LANES];

endmodule

// File: rtl/sfu_datapath.sv
// Result datapath and next-flag derivation for one operation.
// Assumes DATA_W > LOW_W > NIBBLE_BIT. In byte mode the upper operand bits are ignored.
module sfu_datapath
    import sfu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LOW_W  = 8
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [2:0]        code,
    input  logic              wide,
    input  logic              carry_in,
    output logic [DATA_W-1:0] res_out,
    output stat_flags_t       next_stat,
    output logic              code_valid
);

    localparam int EXT_W  = DATA_W + 1;
    localparam int IDXE_W = $clog2(EXT_W);
    localparam int IDXR_W = $clog2(DATA_W);
    localparam int HI_W   = DATA_W - LOW_W;

    logic [DATA_W-1:0] a_m, b_m, logic_res, res_m, nib_v;
    logic [EXT_W-1:0]  ext_sum, ext_dif, ext_sel;
    logic [EXT_W-1:0]  cin_ext;
    logic [IDXR_W-1:0] msb_idx;
    logic [IDXE_W-1:0] cout_idx;
    logic              is_arith, is_sub, use_cin, par_even;
    sfu_op_e           op_e;

    assign op_e = sfu_op_e'(code);

    // Width-dependent operand masking and bit positions
    always_comb begin
        a_m      = wide ? a_in : {{HI_W{1'b0}}, a_in[LOW_W-1:0]};
        b_m      = wide ? b_in : {{HI_W{1'b0}}, b_in[LOW_W-1:0]};
        msb_idx  = wide ? IDXR_W'(DATA_W - 1) : IDXR_W'(LOW_W - 1);
        cout_idx = wide ? IDXE_W'(DATA_W) : IDXE_W'(LOW_W);
    end

    // Operation class decode
    always_comb begin
        is_arith   = (op_e == OP_ADD) || (op_e == OP_ADC) || (op_e == OP_SUB) || (op_e == OP_SBB);
        is_sub     = (op_e == OP_SUB) || (op_e == OP_SBB);
        use_cin    = (op_e == OP_ADC) || (op_e == OP_SBB);
        code_valid = (op_e != OP_NOP);
    end

    // Extended adder and subtractor with the chained carry
    always_comb begin
        cin_ext = {{DATA_W{1'b0}}, (use_cin & carry_in)};
        ext_sum = {1'b0, a_m} + {1'b0, b_m} + cin_ext;
        ext_dif = {1'b0, a_m} - {1'b0, b_m} - cin_ext;
        ext_sel = is_sub ? ext_dif : ext_sum;
    end

    // Bitwise result for the logic codes and the NOP pass-through
    always_comb begin
        case (op_e)
            OP_AND:  logic_res = a_m & b_m;
            OP_OR:   logic_res = a_m | b_m;
            OP_XOR:  logic_res = a_m ^ b_m;
            default: logic_res = a_m;
        endcase
    end

    // Final result, masked to the operation width
    always_comb begin
        res_m = is_arith ? ext_sel[DATA_W-1:0] : logic_res;
        if (!wide) res_m[DATA_W-1:LOW_W] = '0;
    end

    assign res_out = res_m;
    assign nib_v   = a_m ^ b_m ^ res_m;

    sfu_parity #(.LANES(LOW_W)) u_par (
        .bits_in  (res_m[LOW_W-1:0]),
        .even_out (par_even)
    );

    // Flag derivation from the result and operand signs
    always_comb begin
        next_stat.parity = par_even;
        next_stat.zero   = (res_m == '0);
        next_stat.sign   = res_m[msb_idx];
        if (is_arith) begin
            next_stat.carry = ext_sel[cout_idx];
            next_stat.aux   = nib_v[NIBBLE_BIT];
            if (is_sub)
                next_stat.ovf = (a_m[msb_idx] != b_m[msb_idx]) && (res_m[msb_idx] != a_m[msb_idx]);
            else
                next_stat.ovf = (a_m[msb_idx] == b_m[msb_idx]) && (res_m[msb_idx] != a_m[msb_idx]);
        end else begin
            next_stat.carry = 1'b0;
            next_stat.aux   = 1'b0;
            next_stat.ovf   = 1'b0;
        end
    end

endmodule

// File: rtl/sfu_flag_reg.sv
// Flag storage: status flags with a write enable, control bits with set/clear masks.
// Assumes a synchronous active-low reset. Set has priority over clear.
module sfu_flag_reg
    import sfu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stat_load,
    input  stat_flags_t stat_d,
    input  ctl_flags_t  ctl_set_m,
    input  ctl_flags_t  ctl_clr_m,
    output stat_flags_t stat_q,
    output ctl_flags_t  ctl_q
);

    // Status flag capture
    always_ff @(posedge clk) begin
        if (!rst_n)         stat_q <= '0;
        else if (stat_load) stat_q <= stat_d;
    end

    // Control bit set/clear update
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= (ctl_q & ~ctl_clr_m) | ctl_set_m;
    end

endmodule

// File: rtl/status_flag_unit.sv
// Top of the status flag unit: combinational result plus registered flags.
// Assumes operands are stable before the edge on which flag_we is sampled.
module status_flag_unit
    import sfu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LOW_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DATA_W-1:0]       op_a,
    input  logic [DATA_W-1:0]       op_b,
    input  logic [2:0]              op_code,
    input  logic                    word_sel,
    input  logic                    flag_we,
    input  logic [CTL_W-1:0]        ctl_set,
    input  logic [CTL_W-1:0]        ctl_clr,
    output logic [DATA_W-1:0]       result,
    output logic [STAT_W+CTL_W-1:0] flags
);

    stat_flags_t next_stat, stat_q;
    ctl_flags_t  ctl_q;
    logic        code_valid;

    sfu_datapath #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_dp (
        .a_in       (op_a),
        .b_in       (op_b),
        .code       (op_code),
        .wide       (word_sel),
        .carry_in   (stat_q.carry),
        .res_out    (result),
        .next_stat  (next_stat),
        .code_valid (code_valid)
    );

    sfu_flag_reg u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_load (flag_we & code_valid),
        .stat_d    (next_stat),
        .ctl_set_m (ctl_flags_t'(ctl_set)),
        .ctl_clr_m (ctl_flags_t'(ctl_clr)),
        .stat_q    (stat_q),
        .ctl_q     (ctl_q)
    );

    assign flags = {ctl_q, stat_q};

endmodule

// File: rtl/sfu_checker.sv
// Assertion checker for status_flag_unit, attached with bind.
// Observes ports only. Assumes the flag layout of the brief.
module sfu_checker #(
    parameter int DATA_W = 16,
    parameter int LOW_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic [2:0]        op_code,
    input logic              word_sel,
    input logic              flag_we,
    input logic [2:0]        ctl_set,
    input logic [2:0]        ctl_clr,
    input logic [DATA_W-1:0] result,
    input logic [8:0]        flags
);

    // R8: status flags hold without a write enable
    a_r8_hold_no_we: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(flags[5:0]));

    // R8: code 7 never updates the status flags
    a_r8_nop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd7) |=> $stable(flags[5:0]));

    // R7: logic codes clear carry, auxiliary carry and overflow
    a_r7_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_code >= 3'd4 && op_code <= 3'd6) |=> (flags[0] == 1'b0 && flags[2] == 1'b0 && flags[5] == 1'b0));

    // R5: parity captured from the low byte of the presented result
    a_r5_parity_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_code != 3'd7) |=> (flags[1] == ~^$past(result[LOW_W-1:0])));

    // R6: a zero result never carries a set sign
    a_r6_zero_not_negative: assert property (@(posedge clk) disable iff (!rst_n)
        !(flags[3] && flags[4]));

    // R6: byte mode keeps the upper result bits clear
    a_r6_byte_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !word_sel |-> (result[DATA_W-1:LOW_W] == '0));

    // R9: control bits stay put without set or clear requests
    a_r9_ctl_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_set == 3'b000 && ctl_clr == 3'b000) |=> $stable(flags[8:6]));

    // R9: a set request wins
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_set != 3'b000) |=> ((flags[8:6] & $past(ctl_set)) == $past(ctl_set)));

    // R10: reset clears the whole vector
    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (flags == 9'd0));

endmodule

bind status_flag_unit sfu_checker #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_chk (.*);

// File: tb/status_flag_unit_tb.sv
module status_flag_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] op_a, op_b;
    logic [2:0]  op_code;
    logic        word_sel, flag_we;
    logic [2:0]  ctl_set, ctl_clr;
    logic [15:0] result;
    logic [8:0]  flags;

    int n_checks = 0;
    int n_fails  = 0;
    logic [8:0] exp_flags;

    always #5 clk = ~clk;

    status_flag_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_code(op_code),
        .word_sel(word_sel), .flag_we(flag_we), .ctl_set(ctl_set), .ctl_clr(ctl_clr),
        .result(result), .flags(flags)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One operation: check the result before the edge, the flags after it
    task automatic do_op(input logic [15:0] a, input logic [15:0] b, input logic [2:0] op,
                         input logic w, input logic we, input logic [2:0] s, input logic [2:0] c);
        int n, mask, half, ai, bi, cin, raw, res, sa, sb, sres, ones;
        logic cf, pf, af, zf, sf, of;
        string rtag;
        @(negedge clk);
        op_a = a; op_b = b; op_code = op; word_sel = w; flag_we = we; ctl_set = s; ctl_clr = c;
        #1;
        n    = w ? 16 : 8;
        mask = (1 << n) - 1;
        half = 1 << (n - 1);
        ai   = int'(a) & mask;
        bi   = int'(b) & mask;
        cin  = (op == 3'd1 || op == 3'd3) ? int'(exp_flags[0]) : 0;
        sa   = (ai >= half) ? ai - (1 << n) : ai;
        sb   = (bi >= half) ? bi - (1 << n) : bi;
        cf = 0; af = 0; of = 0;
        case (op)
            3'd0, 3'd1: begin
                raw = ai + bi + cin;    res = raw & mask; cf = (raw > mask);
                af = (((ai & 15) + (bi & 15) + cin) > 15);
                sres = sa + sb + cin;   of = (sres < -half) || (sres > half - 1);
                rtag = "R1";
            end
            3'd2, 3'd3: begin
                raw = ai - bi - cin;    res = raw & mask; cf = (raw < 0);
                af = (((ai & 15) - (bi & 15) - cin) < 0);
                sres = sa - sb - cin;   of = (sres < -half) || (sres > half - 1);
                rtag = "R2";
            end
            3'd4: begin res = ai & bi; rtag = "R7"; end
            3'd5: begin res = ai | bi; rtag = "R7"; end
            3'd6: begin res = ai ^ bi; rtag = "R7"; end
            default: begin res = ai; rtag = "R8"; end
        endcase
        chk({rtag, " result"}, int'(result), res);
        ones = 0;
        for (int i = 0; i < 8; i++) ones += (res >> i) & 1;
        pf = (ones % 2 == 0);
        zf = (res == 0);
        sf = ((res >> (n - 1)) & 1) == 1;
        if (we && op != 3'd7) exp_flags[5:0] = {of, sf, zf, af, pf, cf};
        exp_flags[8:6] = (exp_flags[8:6] & ~c) | s;
        @(posedge clk);
        #1;
        if (!we || op == 3'd7) begin
            chk("R8 status hold", int'(flags[5:0]), int'(exp_flags[5:0]));
        end else begin
            chk(op >= 3'd4 ? "R7 carry" : (op >= 3'd2 ? "R2 carry" : "R1 carry"), int'(flags[0]), int'(exp_flags[0]));
            chk("R5 parity", int'(flags[1]), int'(exp_flags[1]));
            chk(op >= 3'd4 ? "R7 aux" : "R4 aux", int'(flags[2]), int'(exp_flags[2]));
            chk("R6 zero", int'(flags[3]), int'(exp_flags[3]));
            chk("R6 sign", int'(flags[4]), int'(exp_flags[4]));
            chk(op >= 3'd4 ? "R7 overflow" : "R3 overflow", int'(flags[5]), int'(exp_flags[5]));
        end
        chk("R9 control", int'(flags[8:6]), int'(exp_flags[8:6]));
    endtask

    initial begin
        #(10 * 200000);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op_a = '0; op_b = '0; op_code = '0; word_sel = 1'b0;
        flag_we = 1'b0; ctl_set = 3'b111; ctl_clr = 3'b000;
        exp_flags = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset flags", int'(flags), 0);
        rst_n = 1'b1; ctl_set = '0;

        // R3 R4 byte add to 0x80: overflow, nibble carry, sign
        do_op(16'h007F, 16'h0001, 3'd0, 1'b0, 1'b1, 3'b000, 3'b000);
        // R1 R6 byte wrap to zero with carry
        do_op(16'hAAFF, 16'h5501, 3'd0, 1'b0, 1'b1, 3'b000, 3'b000);
        // R1 add with carry uses stored carry
        do_op(16'h0010, 16'h0020, 3'd1, 1'b0, 1'b1, 3'b000, 3'b000);
        // R2 word borrow
        do_op(16'h0000, 16'h0001, 3'd2, 1'b1, 1'b1, 3'b000, 3'b000);
        // R2 R3 subtract with borrow, signed overflow
        do_op(16'h8000, 16'h0001, 3'd3, 1'b1, 1'b1, 3'b000, 3'b000);
        // R5 word parity from low byte only
        do_op(16'h0100, 16'h0003, 3'd5, 1'b1, 1'b1, 3'b000, 3'b000);
        // R2 set carry again, then R7 logic clears it
        do_op(16'h0001, 16'h0002, 3'd2, 1'b0, 1'b1, 3'b000, 3'b000);
        do_op(16'h00F0, 16'h00FF, 3'd4, 1'b0, 1'b1, 3'b000, 3'b000);
        // R8 no write enable: flags hold
        do_op(16'h0000, 16'h0000, 3'd6, 1'b1, 1'b0, 3'b000, 3'b000);
        // R8 code 7 with enable: flags hold, result passes op_a
        do_op(16'h1234, 16'h0000, 3'd7, 1'b1, 1'b1, 3'b000, 3'b000);
        do_op(16'h1234, 16'h0000, 3'd7, 1'b0, 1'b1, 3'b000, 3'b000);
        // R9 set, clear, and set priority during arithmetic
        do_op(16'h7FFF, 16'h0001, 3'd0, 1'b1, 1'b1, 3'b101, 3'b000);
        do_op(16'h0003, 16'h0004, 3'd2, 1'b1, 1'b1, 3'b000, 3'b001);
        do_op(16'h0000, 16'h0000, 3'd0, 1'b1, 1'b1, 3'b010, 3'b110);

        // Mixed random sweep
        for (int k = 0; k < 600; k++) begin
            do_op(16'($urandom), 16'($urandom), 3'($urandom), 1'($urandom),
                  ($urandom % 4) != 0, 3'($urandom % 8 == 0 ? $urandom : 0),
                  3'($urandom % 8 == 1 ? $urandom : 0));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule